// File: doc/BRIEF.md
# NAND Bus Strobe Timing Generator

This block sequences single-byte transfers on an 8-bit NAND flash bus. A host asks for one command byte, one address byte, one data byte to write or one data byte to read. The block then drives the latch enables, the chip enable, the write and read strobes and the data bus. Each phase of a transfer lasts a number of system clocks taken from a packed timing word.

The timing word, an interface setup register and a chip-enable control register sit behind a write guard. A configuration write lands only when the write just before it on the configuration port was the unlock key. A transfer can be flagged as one that makes the flash busy. The controller then waits a programmed delay before it looks at the ready/busy line, and stays busy until the flash reports ready.

Top module: `nand_strobe_gen`

## Requirements
- R1: The timing word holds a write-strobe low count in bits 3:0 and a write-strobe high count in bits 7:4. A write-direction transfer (request kinds 0, 1, 2) holds WE low for exactly that many clocks and then high for that many clocks. A count of 0 behaves as 1. RE stays high for the whole transfer.
- R2: The timing word holds a read-strobe low count in bits 11:8 and a read-strobe high count in bits 15:12 (0 behaves as 1). A read (request kind 3) holds RE low and then high for those counts. The bus byte present in the last RE-low clock appears on `rd_data`, with `rd_valid` high for exactly one clock, in the first RE-high clock.
- R3: When bit 0 of the chip-enable register (select 3) is 1, CE goes low a number of clocks before the strobe equal to the count in timing bits 25:24 (0 behaves as 1). CE goes high again after the strobe-high phase. When that bit is 0, CE is low at all times, idle included, and no lead phase is inserted.
- R4: A read whose previous transfer was write-direction first waits the turnaround count in timing bits 18:16 (0 behaves as 1). During that wait no strobe is low and, in normal chip-enable mode, CE is high. Reads after reads and writes after anything insert no wait.
- R5: A transfer requested with `req_busy` set keeps `ctrl_ready` low after its strobe-high phase. It waits the busy-delay count in timing bits 23:19 (0 behaves as 1) without looking at the ready/busy line, then waits until the registered ready line is high. With the line already high, the busy tail lasts the delay count plus one clock.
- R6: Configuration writes to select 1 (timing), 2 (interface) and 3 (chip-enable) take effect only if the configuration write before them was 0x0000A25E to select 0 (lock). Any write to selects 1 to 3, and any other value written to select 0, closes the guard. Clocks with no configuration write leave it as it is.
- R7: The interface register (select 2) drives `cfg_large_page` from bit 2 and `cfg_addr4` from bit 1.
- R8: CLE is high throughout a kind-0 (command) transfer and ALE throughout a kind-1 (address) transfer. Neither is high for data. During the strobe-low and strobe-high phases of a write-direction transfer, `nand_dq_oe` is 1 and `nand_dq_out` carries the request byte.
- R9: `nand_ready` is `nand_rb_n` delayed by one clock. `ctrl_ready` is 1 only when the sequencer is idle, and a request presented while `ctrl_ready` is 0 is dropped.
- R10: After reset, CE, WE and RE are high, CLE, ALE and `nand_dq_oe` are low, and `ctrl_ready` is 1. The timing word is all zeros, chip-enable mode is normal and the guard is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 lock, 1 timing, 2 interface, 3 chip-enable |
| cfg_wdata | input | CFG_W | Configuration write data |
| req_valid | input | 1 | Transfer request, taken when `ctrl_ready` is 1 |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_byte | input | DATA_W | Byte to place on the bus |
| req_busy | input | 1 | Transfer leaves the flash busy |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | DATA_W | Bus data driven by the block |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | DATA_W | Bus data from the flash |
| nand_rb_n | input | 1 | Ready/busy line, high when ready |
| rd_data | output | DATA_W | Byte captured by the last read |
| rd_valid | output | 1 | One-clock pulse when `rd_data` is new |
| nand_ready | output | 1 | Registered ready/busy line |
| ctrl_ready | output | 1 | Sequencer idle and able to take a request |
| cfg_large_page | output | 1 | Large-page device selected |
| cfg_addr4 | output | 1 | Four address cycles selected |

## Verification
The bench sweeps the strobe-low and strobe-high counts through zero and small values for both directions, and runs the widest 4-bit and 5-bit counts. A design that let a zero field make a phase vanish, or that counted one clock too many or too few, fails on the measured widths. Reads are mixed with writes so that a missing or spurious turnaround wait shows up. The guard is probed with no key, a wrong key, a key spent on another register and a second write after one key, so a lock that stayed open would let a timing change through that the bench does not expect. A busy command is held with the ready line low for a long time, which catches a controller that ignores the line after the delay or accepts a request while stalled.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

  localparam int TIMING_W = 26;
  localparam int CNT_W    = 5;

  localparam logic [1:0] SEL_LOCK   = 2'd0;
  localparam logic [1:0] SEL_TIMING = 2'd1;
  localparam logic [1:0] SEL_IFACE  = 2'd2;
  localparam logic [1:0] SEL_CECTL  = 2'd3;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_WDATA = 2'd2,
    KIND_RDATA = 2'd3
  } xfer_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_CEA,
    ST_LOW,
    ST_HIGH,
    ST_BUSY,
    ST_WAITRB
  } seq_state_e;

  typedef struct packed {
    logic [1:0] cea;
    logic [4:0] busy;
    logic [2:0] turn;
    logic [3:0] rd_hi;
    logic [3:0] rd_lo;
    logic [3:0] wr_hi;
    logic [3:0] wr_lo;
  } timing_t;

  function automatic timing_t unpack_timing(input logic [TIMING_W-1:0] w);
    timing_t t;
    t.wr_lo = w[3:0];
    t.wr_hi = w[7:4];
    t.rd_lo = w[11:8];
    t.rd_hi = w[15:12];
    t.turn  = w[18:16];
    t.busy  = w[23:19];
    t.cea   = w[25:24];
    return t;
  endfunction

  // phase of length max(f,1) clocks: counter starts at length-1
  function automatic logic [CNT_W-1:0] reload_of(input logic [CNT_W-1:0] f);
    return (f == '0) ? '0 : f - 1'b1;
  endfunction

endpackage

// File: rtl/nand_cfg_regs.sv
module nand_cfg_regs
  import nand_strobe_pkg::*;
#(
  parameter int              CFG_W = 32,
  parameter logic [CFG_W-1:0] KEY  = 32'h0000A25E
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [1:0]          sel,
  input  logic [CFG_W-1:0]    wdata,
  output logic [TIMING_W-1:0] timing_q,
  output logic                large_page,
  output logic                addr4,
  output logic                ce_normal,
  output logic                unlocked
);

  logic unused_hi_bits;
  assign unused_hi_bits = ^wdata[CFG_W-1:TIMING_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked   <= 1'b0;
      timing_q   <= '0;
      large_page <= 1'b0;
      addr4      <= 1'b0;
      ce_normal  <= 1'b1;
    end else if (we) begin
      if (sel == SEL_LOCK) begin
        unlocked <= (wdata == KEY);
      end else begin
        unlocked <= 1'b0;
        if (unlocked) begin
          unique case (sel)
            SEL_TIMING: timing_q <= wdata[TIMING_W-1:0];
            SEL_IFACE: begin
              large_page <= wdata[2];
              addr4      <= wdata[1];
            end
            default:    ce_normal <= wdata[0];
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)                count <= '0;
    else if (load)          count <= load_val;
    else if (count != '0)   count <= count - 1'b1;
  end

  assign done = (count == '0);

endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nand_strobe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  timing_t           tm,
  input  logic              ce_normal,
  input  logic              req_valid,
  input  xfer_kind_e        req_kind,
  input  logic [DATA_W-1:0] req_byte,
  input  logic              req_busy,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              rb_ready,
  input  logic              t_done,
  output logic              t_load,
  output logic [CNT_W-1:0]  t_val,
  output logic              cle,
  output logic              ale,
  output logic              ce_n,
  output logic              we_n,
  output logic              re_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              ctrl_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  seq_state_e        state, state_n;
  xfer_kind_e        op_kind, op_kind_n;
  logic [DATA_W-1:0] op_byte, op_byte_n;
  logic              op_busy, op_busy_n;
  logic              last_wr;
  logic              accept, is_rd_n, capture;
  logic              active_d, wdir_d;

  assign accept = (state == ST_IDLE) && req_valid;

  always_comb begin
    state_n   = state;
    op_kind_n = op_kind;
    op_byte_n = op_byte;
    op_busy_n = op_busy;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        op_kind_n = req_kind;
        op_byte_n = req_byte;
        op_busy_n = req_busy;
        if (req_kind == KIND_RDATA && last_wr) state_n = ST_TURN;
        else if (ce_normal)                    state_n = ST_CEA;
        else                                   state_n = ST_LOW;
      end
      ST_TURN:   if (t_done) state_n = ce_normal ? ST_CEA : ST_LOW;
      ST_CEA:    if (t_done) state_n = ST_LOW;
      ST_LOW:    if (t_done) state_n = ST_HIGH;
      ST_HIGH:   if (t_done) state_n = op_busy ? ST_BUSY : ST_IDLE;
      ST_BUSY:   if (t_done) state_n = ST_WAITRB;
      ST_WAITRB: if (rb_ready) state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  assign is_rd_n = (op_kind_n == KIND_RDATA);

  // phase length loaded whenever a new state is entered
  always_comb begin
    t_load = (state_n != state);
    unique case (state_n)
      ST_TURN: t_val = reload_of(CNT_W'(tm.turn));
      ST_CEA:  t_val = reload_of(CNT_W'(tm.cea));
      ST_LOW:  t_val = reload_of(is_rd_n ? CNT_W'(tm.rd_lo) : CNT_W'(tm.wr_lo));
      ST_HIGH: t_val = reload_of(is_rd_n ? CNT_W'(tm.rd_hi) : CNT_W'(tm.wr_hi));
      ST_BUSY: t_val = reload_of(tm.busy);
      default: t_val = '0;
    endcase
  end

  assign active_d = (state_n == ST_CEA) || (state_n == ST_LOW) || (state_n == ST_HIGH);
  assign wdir_d   = !is_rd_n && ((state_n == ST_LOW) || (state_n == ST_HIGH));
  assign capture  = (state == ST_LOW) && (state_n == ST_HIGH) && (op_kind == KIND_RDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      op_kind    <= KIND_CMD;
      op_byte    <= '0;
      op_busy    <= 1'b0;
      last_wr    <= 1'b0;
      cle        <= 1'b0;
      ale        <= 1'b0;
      ce_n       <= 1'b1;
      we_n       <= 1'b1;
      re_n       <= 1'b1;
      dq_out     <= '0;
      dq_oe      <= 1'b0;
      ctrl_ready <= 1'b1;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      state      <= state_n;
      op_kind    <= op_kind_n;
      op_byte    <= op_byte_n;
      op_busy    <= op_busy_n;
      if (accept) last_wr <= (req_kind != KIND_RDATA);
      cle        <= active_d && (op_kind_n == KIND_CMD);
      ale        <= active_d && (op_kind_n == KIND_ADDR);
      ce_n       <= ce_normal ? !active_d : 1'b0;
      we_n       <= !((state_n == ST_LOW) && !is_rd_n);
      re_n       <= !((state_n == ST_LOW) && is_rd_n);
      dq_out     <= op_byte_n;
      dq_oe      <= wdir_d;
      ctrl_ready <= (state_n == ST_IDLE);
      rd_valid   <= capture;
      if (capture) rd_data <= dq_in;
    end
  end

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nand_strobe_pkg::*;
#(
  parameter int               DATA_W = 8,
  parameter int               CFG_W  = 32,
  parameter logic [CFG_W-1:0] KEY    = 32'h0000A25E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_byte,
  input  logic              req_busy,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_ce_n,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rb_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              nand_ready,
  output logic              ctrl_ready,
  output logic              cfg_large_page,
  output logic              cfg_addr4
);

  logic [TIMING_W-1:0] timing_q;
  timing_t             tm;
  logic                ce_normal, cfg_unlocked;
  logic                t_load, t_done;
  logic [CNT_W-1:0]    t_val;

  // ready/busy line registered once before any use
  always_ff @(posedge clk) nand_ready <= nand_rb_n;

  nand_cfg_regs #(.CFG_W(CFG_W), .KEY(KEY)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .timing_q(timing_q), .large_page(cfg_large_page), .addr4(cfg_addr4),
    .ce_normal(ce_normal), .unlocked(cfg_unlocked)
  );

  assign tm = unpack_timing(timing_q);

  nand_phase_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
  );

  nand_bus_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .tm(tm), .ce_normal(ce_normal),
    .req_valid(req_valid), .req_kind(xfer_kind_e'(req_kind)),
    .req_byte(req_byte), .req_busy(req_busy), .dq_in(nand_dq_in),
    .rb_ready(nand_ready), .t_done(t_done), .t_load(t_load), .t_val(t_val),
    .cle(nand_cle), .ale(nand_ale), .ce_n(nand_ce_n), .we_n(nand_we_n),
    .re_n(nand_re_n), .dq_out(nand_dq_out), .dq_oe(nand_dq_oe),
    .ctrl_ready(ctrl_ready), .rd_data(rd_data), .rd_valid(rd_valid)
  );

endmodule

// File: rtl/nand_strobe_chk.sv
module nand_strobe_chk #(
  parameter int               CFG_W = 32,
  parameter logic [CFG_W-1:0] KEY   = 32'h0000A25E
) (
  input logic             clk,
  input logic             rst,
  input logic             ce_n,
  input logic             we_n,
  input logic             re_n,
  input logic             cle,
  input logic             ale,
  input logic             dq_oe,
  input logic             ctrl_ready,
  input logic             rd_valid,
  input logic             rb_n,
  input logic             nand_ready,
  input logic             cfg_we,
  input logic [1:0]       cfg_sel,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic             unlocked
);

  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));

  assert_strobe_under_ce_R3: assert property (@(posedge clk) disable iff (rst)
    (!we_n || !re_n) |-> !ce_n);

  assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  assert_latch_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));

  assert_we_drives_bus_R8: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> dq_oe);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ctrl_ready |-> (we_n && re_n && !cle && !ale && !dq_oe));

  assert_rb_delay_R9: assert property (@(posedge clk) disable iff (rst)
    nand_ready == $past(rb_n));

  assert_key_opens_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd0 && cfg_wdata == KEY) |=> unlocked);

  assert_guard_closes_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel != 2'd0) |=> !unlocked);

endmodule

bind nand_strobe_gen nand_strobe_chk #(.CFG_W(CFG_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst(rst), .ce_n(nand_ce_n), .we_n(nand_we_n), .re_n(nand_re_n),
  .cle(nand_cle), .ale(nand_ale), .dq_oe(nand_dq_oe), .ctrl_ready(ctrl_ready),
  .rd_valid(rd_valid), .rb_n(nand_rb_n), .nand_ready(nand_ready),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .unlocked(cfg_unlocked)
);

// File: tb/test_nand_strobe_gen.sv
module test_nand_strobe_gen;

  localparam int          DW  = 8;
  localparam logic [31:0] KEY = 32'h0000A25E;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_kind = '0;
  logic [DW-1:0] req_byte = '0;
  logic          req_busy = 1'b0;
  logic          nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n;
  logic [DW-1:0] nand_dq_out;
  logic          nand_dq_oe;
  logic [DW-1:0] nand_dq_in = '0;
  logic          nand_rb_n = 1'b1;
  logic [DW-1:0] rd_data;
  logic          rd_valid, nand_ready, ctrl_ready, cfg_large_page, cfg_addr4;

  always #2 clk = ~clk;

  nand_strobe_gen i_nand_strobe_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_kind(req_kind), .req_byte(req_byte), .req_busy(req_busy),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n),
    .rd_data(rd_data), .rd_valid(rd_valid), .nand_ready(nand_ready),
    .ctrl_ready(ctrl_ready), .cfg_large_page(cfg_large_page), .cfg_addr4(cfg_addr4)
  );

  int n_chk = 0;
  int n_bad = 0;

  // model of the applied configuration
  int m_wl = 0, m_wh = 0, m_rl = 0, m_rh = 0, m_ta = 0, m_bs = 0, m_ce = 0;
  bit m_normal = 1'b1;
  bit m_last_wr = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int plen(input int f);
    return (f == 0) ? 1 : f;
  endfunction

  function automatic logic [31:0] pack(input int wl, wh, rl, rh, ta, bs, ce);
    return {6'b0, 2'(ce), 5'(bs), 3'(ta), 4'(rh), 4'(rl), 4'(wh), 4'(wl)};
  endfunction

  task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_timing(input int wl, wh, rl, rh, ta, bs, ce);
    cfg_write(2'd0, KEY);
    cfg_write(2'd1, pack(wl, wh, rl, rh, ta, bs, ce));
    m_wl = wl; m_wh = wh; m_rl = rl; m_rh = rh; m_ta = ta; m_bs = bs; m_ce = ce;
  endtask

  task automatic run_xfer(input int kind, input logic [DW-1:0] b, input bit busy);
    int n_pre = 0, n_turn = 0, n_low = 0, n_post = 0, n_after = 0, n_other = 0, n_rd = 0;
    bit seen_low = 0, cle_s = 0, ale_s = 0, oe_s = 0, rd = (kind == 3), strobe, other;
    logic [DW-1:0] dq_s = '0, rd_s = '0, rd_exp;
    int turn_len, e_pre, e_turn, e_low, e_high, e_post, e_after, busy_len;
    rd_exp = b ^ 8'h5A;
    @(negedge clk);
    nand_dq_in = rd_exp;
    req_valid = 1'b1; req_kind = 2'(kind); req_byte = b; req_busy = busy;
    @(negedge clk);
    req_valid = 1'b0; req_busy = 1'b0;
    for (int it = 0; it < 400 && !ctrl_ready; it++) begin
      strobe = rd ? nand_re_n : nand_we_n;
      other  = rd ? nand_we_n : nand_re_n;
      if (!other) n_other++;
      if (!strobe) begin
        n_low++; seen_low = 1;
        cle_s = nand_cle; ale_s = nand_ale; dq_s = nand_dq_out; oe_s = nand_dq_oe;
      end else if (!seen_low) begin
        if (!nand_ce_n) n_pre++; else n_turn++;
      end else begin
        if (!nand_ce_n) n_post++; else n_after++;
      end
      if (rd_valid) begin n_rd++; rd_s = rd_data; end
      @(negedge clk);
    end
    turn_len = (rd && m_last_wr) ? plen(m_ta) : 0;
    busy_len = busy ? plen(m_bs) + 1 : 0;
    e_low  = plen(rd ? m_rl : m_wl);
    e_high = plen(rd ? m_rh : m_wh);
    if (m_normal) begin
      e_turn = turn_len; e_pre = plen(m_ce); e_post = e_high; e_after = busy_len;
    end else begin
      e_turn = 0; e_pre = turn_len; e_post = e_high + busy_len; e_after = 0;
    end
    chk(n_low == e_low, rd ? "R2 read-low width" : "R1 write-low width", n_low, e_low);
    chk(n_post == e_post, rd ? "R2 read-high width" : "R1 write-high width", n_post, e_post);
    chk(n_other == 0, "R1 opposite strobe stays high", n_other, 0);
    chk(n_pre == e_pre, "R3 CE lead before strobe", n_pre, e_pre);
    chk(n_turn == e_turn, "R4 turnaround wait", n_turn, e_turn);
    chk(n_after == e_after, "R5 busy tail", n_after, e_after);
    chk(cle_s == (kind == 0), "R8 CLE level", cle_s, kind == 0);
    chk(ale_s == (kind == 1), "R8 ALE level", ale_s, kind == 1);
    if (rd) begin
      chk(n_rd == 1, "R2 rd_valid pulse count", n_rd, 1);
      chk(rd_s == rd_exp, "R2 captured byte", rd_s, rd_exp);
    end else begin
      chk(oe_s && dq_s == b, "R8 bus byte driven", dq_s, b);
    end
    m_last_wr = !rd;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(nand_ce_n == 1'b1, "R10 CE high after reset", nand_ce_n, 1);
    chk(nand_we_n && nand_re_n, "R10 strobes high after reset", {nand_we_n, nand_re_n}, 3);
    chk(!nand_cle && !nand_ale && !nand_dq_oe, "R10 latches and bus idle", {nand_cle, nand_ale, nand_dq_oe}, 0);
    chk(ctrl_ready == 1'b1, "R10 controller ready", ctrl_ready, 1);
    chk(!cfg_large_page && !cfg_addr4, "R10 interface bits clear", {cfg_large_page, cfg_addr4}, 0);
    chk(nand_ready == 1'b1, "R9 ready follows line", nand_ready, 1);
    run_xfer(2, 8'hA5, 0);  // reset timing: all ones

    // R6 guard: write with no key is dropped
    cfg_write(2'd1, pack(5, 5, 5, 5, 5, 5, 3));
    run_xfer(2, 8'h11, 0);
    // R6 wrong key
    cfg_write(2'd0, KEY ^ 32'h1);
    cfg_write(2'd1, pack(6, 6, 6, 6, 6, 6, 2));
    run_xfer(2, 8'h22, 0);
    // R7 interface bits, and the key is spent by that write (R6)
    cfg_write(2'd0, KEY);
    cfg_write(2'd2, 32'h6);
    chk(cfg_large_page && cfg_addr4, "R7 both interface bits set", {cfg_large_page, cfg_addr4}, 3);
    cfg_write(2'd1, pack(7, 7, 7, 7, 7, 7, 3));
    run_xfer(2, 8'h33, 0);
    cfg_write(2'd0, KEY);
    cfg_write(2'd2, 32'h4);
    chk(cfg_large_page && !cfg_addr4, "R7 large page only", {cfg_large_page, cfg_addr4}, 2);
    cfg_write(2'd0, KEY);
    cfg_write(2'd2, 32'h2);
    chk(!cfg_large_page && cfg_addr4, "R7 four address cycles only", {cfg_large_page, cfg_addr4}, 1);
    // R6 key survives idle clocks, second write after one key is dropped
    cfg_write(2'd0, KEY);
    repeat (5) @(negedge clk);
    cfg_write(2'd1, pack(3, 2, 1, 1, 2, 1, 2));
    m_wl = 3; m_wh = 2; m_rl = 1; m_rh = 1; m_ta = 2; m_bs = 1; m_ce = 2;
    cfg_write(2'd1, pack(9, 9, 9, 9, 7, 9, 3));
    run_xfer(2, 8'h44, 0);

    // R1 / R8 sweep of write-strobe counts
    for (int wl = 0; wl < 6; wl++) begin
      for (int wh = 0; wh < 6; wh++) begin
        set_timing(wl, wh, 1, 1, 2, 1, 1);
        run_xfer(2, 8'(wl * 16 + wh), 0);
      end
    end
    run_xfer(0, 8'h30, 0);
    run_xfer(1, 8'h07, 0);

    // R2 / R4 sweep of read-strobe counts with mixed directions
    for (int rl = 0; rl < 6; rl++) begin
      for (int rh = 0; rh < 6; rh++) begin
        set_timing(1, 2, rl, rh, rl % 8, 1, rh % 4);
        if (rh % 2 == 1) run_xfer(1, 8'(rh), 0);
        run_xfer(3, 8'(rl * 16 + rh), 0);
      end
    end
    run_xfer(3, 8'hC3, 0);  // read after read: no wait (R4)

    // widest fields, busy command with line already high (R5)
    set_timing(15, 15, 15, 15, 7, 31, 3);
    run_xfer(0, 8'h70, 1);
    run_xfer(3, 8'h99, 0);
    set_timing(2, 1, 2, 1, 0, 0, 0);
    run_xfer(0, 8'h60, 1);

    // R5 / R9 busy line held low
    set_timing(1, 1, 1, 1, 1, 3, 1);
    @(negedge clk);
    nand_rb_n = 1'b0;
    @(negedge clk);
    chk(nand_ready == 1'b0, "R9 ready follows line low", nand_ready, 0);
    req_valid = 1'b1; req_kind = 2'd0; req_byte = 8'hD0; req_busy = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_busy = 1'b0;
    repeat (40) @(negedge clk);
    chk(ctrl_ready == 1'b0, "R5 stays busy while line low", ctrl_ready, 0);
    req_valid = 1'b1; req_kind = 2'd2; req_byte = 8'hEE;
    @(negedge clk);
    req_valid = 1'b0;
    nand_rb_n = 1'b1;
    @(negedge clk);
    chk(ctrl_ready == 1'b0 && nand_ready == 1'b1, "R5 one clock after line rises", ctrl_ready, 0);
    @(negedge clk);
    chk(ctrl_ready == 1'b1, "R5 ready after line rises", ctrl_ready, 1);
    m_last_wr = 1'b1;
    begin
      int quiet = 0;
      for (int k = 0; k < 5; k++) begin
        if (nand_we_n && ctrl_ready && nand_ce_n) quiet++;
        @(negedge clk);
      end
      chk(quiet == 5, "R9 request while busy is dropped", quiet, 5);
    end

    // R3 forced chip enable
    set_timing(2, 1, 1, 2, 3, 2, 3);
    cfg_write(2'd0, KEY);
    cfg_write(2'd3, 32'h0);
    m_normal = 1'b0;
    @(negedge clk);
    chk(nand_ce_n == 1'b0, "R3 CE forced low while idle", nand_ce_n, 0);
    run_xfer(2, 8'h5C, 0);
    run_xfer(3, 8'h3E, 0);
    run_xfer(0, 8'h80, 1);
    cfg_write(2'd0, KEY);
    cfg_write(2'd3, 32'h1);
    m_normal = 1'b1;
    @(negedge clk);
    chk(nand_ce_n == 1'b1, "R3 CE released in normal mode", nand_ce_n, 1);
    run_xfer(3, 8'h17, 0);

    finish_run();
  end

endmodule